// File: doc/BRIEF.md
# Serial DAC Write Controller

This block pushes 16-bit words from a parallel system-side port out to a voltage-output DAC over a transmit-only three-wire link. The three lines are an active-low frame strobe, a serial clock and a data line. The system offers a word with a valid/ready handshake. The controller lowers the frame strobe and toggles the serial clock. It shifts the word out most significant bit first, and the DAC captures each bit on a falling edge of the serial clock.

All link timing comes from the system clock. The clock period and every minimum interval of the link are parameters given in picoseconds. Package functions turn them into whole system cycles, rounding up, so that each limit holds at the configured frequency:

- serial clock period and phase widths;
- frame strobe lead time before the first falling edge;
- data setup and hold around each falling edge;
- minimum strobe-high time between frames;
- the dead window after the strobe rises, during which the DAC ignores falling edges.

With the defaults (4 ns system clock) the derived counts are:

- one serial clock phase lasts 5 cycles;
- the strobe leads the first falling edge by 3 cycles;
- recovery lasts 5 cycles.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is high and in the first cycle after it, the outputs are: frame strobe high, serial clock high, data low, ready high.
- R2: Each accepted word is sent as 16 bits, most significant bit first. The receiver captures one bit on every serial clock falling edge, and the captured word equals the accepted word.
- R3: Each high phase and each low phase of the serial clock inside a frame lasts at least 5 ns. Consecutive falling edges are at least 33 ns apart.
- R4: The frame strobe goes low at least 10 ns before the first serial clock falling edge of the frame.
- R5: The data line settles at least 5 ns before each falling edge. It then stays unchanged for at least 4.5 ns after that edge.
- R6: The serial clock is high whenever the frame strobe is high. The strobe rises only after the last falling edge of the frame.
- R7: Between frames the strobe stays high at least 20 ns. No falling edge occurs within 13 ns after the strobe rises.
- R8: Ready is low from the cycle after a word is accepted until the recovery interval has ended. It is high again at most 8 cycles after the strobe rises. A word held on the input while the block is busy is sent once the block is free and is not lost.
- R9: Every completed frame contains exactly 16 serial clock falling edges.
- R10: The data line is low whenever the frame strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_in | input | 16 | Word to send |
| word_valid | input | 1 | word_in is offered |
| word_ready | output | 1 | Block can take a word this cycle |
| dac_sync_n | output | 1 | Active-low frame strobe |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdata | output | 1 | Serial data, changes on rising edges |

## Verification
The bench watches the link in system cycles and checks every measured gap against a minimum it derives from nanosecond limits. A sequencer that lowered the clock too soon after the strobe, or too soon after the previous frame, would break the lead-time or dead-window check. One that shifted data on the falling edge would break the setup and hold checks. Data patterns that are all zeros, all ones, alternating, or have only the end bits set would expose a swapped order or a lost last bit. A word held during a busy frame must still be sent, and a reset in mid-frame must drop the partial frame and return the link to idle.

// File: rtl/dacw_pkg.sv
`timescale 1ns/1ps
package dacw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_RECOV = 3'd4
  } dacw_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // One serial clock phase: half the minimum period, the phase width,
  // and (because data moves on the opposite edge) data setup and hold.
  function automatic int half_cycles(input int clk_ps, input int period_ps,
                                     input int phase_ps, input int dsu_ps,
                                     input int dh_ps);
    int h;
    h = ceil_div(period_ps, 2 * clk_ps);
    h = max_int(h, ceil_div(phase_ps, clk_ps));
    h = max_int(h, ceil_div(dsu_ps, clk_ps));
    h = max_int(h, ceil_div(dh_ps, clk_ps));
    return max_int(h, 1);
  endfunction

  // Strobe-low to first falling edge; first bit is launched with the strobe.
  function automatic int lead_cycles(input int clk_ps, input int sync_su_ps,
                                     input int dsu_ps);
    return max_int(1, max_int(ceil_div(sync_su_ps, clk_ps),
                              ceil_div(dsu_ps, clk_ps)));
  endfunction

  // Strobe-high hold-off before the block may start a new frame.
  function automatic int recov_cycles(input int clk_ps, input int high_ps,
                                      input int ignore_ps);
    return max_int(1, max_int(ceil_div(high_ps, clk_ps),
                              ceil_div(ignore_ps, clk_ps)));
  endfunction

endpackage

// File: rtl/dacw_timer.sv
`timescale 1ns/1ps
module dacw_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val - CNT_W'(1);
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

  assert_timer_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/dacw_shifter.sv
`timescale 1ns/1ps
module dacw_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic              clear,
  input  logic [WORD_W-1:0] din,
  output logic              sdo
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) sh <= '0;
    else if (load)    sh <= din;
    else if (shift)   sh <= {sh[WORD_W-2:0], 1'b0};
  end

  assign sdo = sh[WORD_W-1];

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (sdo == $past(din[WORD_W-1])));
endmodule

// File: rtl/dacw_seq.sv
`timescale 1ns/1ps
module dacw_seq
  import dacw_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CNT_W     = 3,
  parameter int HALF_CYC  = 5,
  parameter int LEAD_CYC  = 3,
  parameter int RECOV_CYC = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             ready,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift,
  output logic             sh_clear,
  output logic             sync_n,
  output logic             sclk
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int FC_W  = $clog2(WORD_W + 1);

  dacw_state_t      state;
  logic [BIT_W-1:0] bits_left;
  logic             accept, last_bit;
  logic             fall_evt, rise_evt, frame_end;
  logic [FC_W-1:0]  fall_cnt;

  assign ready     = (state == ST_IDLE);
  assign accept    = in_valid && ready;
  assign last_bit  = (bits_left == '0);
  assign fall_evt  = tmr_done && (state == ST_SETUP || state == ST_HIGH);
  assign rise_evt  = tmr_done && (state == ST_LOW);
  assign frame_end = rise_evt && last_bit;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_clear = 1'b0;
    case (state)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LEAD_CYC);
        sh_load  = 1'b1;
      end
      ST_SETUP, ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HALF_CYC);
      end
      ST_LOW: if (tmr_done) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          tmr_val  = CNT_W'(RECOV_CYC);
          sh_clear = 1'b1;
        end else begin
          tmr_val  = CNT_W'(HALF_CYC);
          sh_shift = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sync_n    <= 1'b1;
      sclk      <= 1'b1;
      bits_left <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_SETUP;
          sync_n    <= 1'b0;
          bits_left <= BIT_W'(WORD_W - 1);
        end
        ST_SETUP, ST_HIGH: if (tmr_done) begin
          state <= ST_LOW;
          sclk  <= 1'b0;
        end
        ST_LOW: if (tmr_done) begin
          sclk <= 1'b1;
          if (last_bit) begin
            state  <= ST_RECOV;
            sync_n <= 1'b1;
          end else begin
            state     <= ST_HIGH;
            bits_left <= bits_left - BIT_W'(1);
          end
        end
        ST_RECOV: if (tmr_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Independent count of falling edges, used only to check frame length.
  always_ff @(posedge clk) begin
    if (rst || accept) fall_cnt <= '0;
    else if (fall_evt) fall_cnt <= fall_cnt + FC_W'(1);
  end

  assert_bits_per_frame_R9: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (fall_cnt == FC_W'(WORD_W)));
  assert_idle_clock_high_R6: assert property (@(posedge clk) disable iff (rst)
    sync_n |-> sclk);
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !sync_n |-> !ready);
  assert_accept_starts_R4: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!sync_n && sclk));
endmodule

// File: rtl/dac_serial_writer.sv
`timescale 1ns/1ps
module dac_serial_writer
  import dacw_pkg::*;
#(
  parameter int CLK_PERIOD_PS      = 4000,
  parameter int WORD_W             = 16,
  parameter int SCLK_PERIOD_MIN_PS = 33000,
  parameter int SCLK_PHASE_MIN_PS  = 5000,
  parameter int LEAD_MIN_PS        = 10000,
  parameter int DATA_SETUP_MIN_PS  = 5000,
  parameter int DATA_HOLD_MIN_PS   = 4500,
  parameter int SYNC_HIGH_MIN_PS   = 20000,
  parameter int IGNORE_WIN_PS      = 13000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              dac_sync_n,
  output logic              dac_sclk,
  output logic              dac_sdata
);
  localparam int HALF_CYC  = half_cycles(CLK_PERIOD_PS, SCLK_PERIOD_MIN_PS,
                                         SCLK_PHASE_MIN_PS, DATA_SETUP_MIN_PS,
                                         DATA_HOLD_MIN_PS);
  localparam int LEAD_CYC  = lead_cycles(CLK_PERIOD_PS, LEAD_MIN_PS,
                                         DATA_SETUP_MIN_PS);
  localparam int RECOV_CYC = recov_cycles(CLK_PERIOD_PS, SYNC_HIGH_MIN_PS,
                                          IGNORE_WIN_PS);
  localparam int MAX_CYC   = max_int(HALF_CYC, max_int(LEAD_CYC, RECOV_CYC));
  localparam int CNT_W     = max_int(1, $clog2(MAX_CYC + 1));

  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load, sh_shift, sh_clear;

  dacw_seq #(
    .WORD_W(WORD_W), .CNT_W(CNT_W), .HALF_CYC(HALF_CYC),
    .LEAD_CYC(LEAD_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .in_valid(word_valid), .ready(word_ready),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(sh_shift), .sh_clear(sh_clear),
    .sync_n(dac_sync_n), .sclk(dac_sclk)
  );

  dacw_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  dacw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(sh_load), .shift(sh_shift), .clear(sh_clear),
    .din(word_in), .sdo(dac_sdata)
  );

  assert_data_still_while_low_R5: assert property (@(posedge clk) disable iff (rst)
    !dac_sclk |=> (dac_sclk || $stable(dac_sdata)));
  assert_data_low_idle_R10: assert property (@(posedge clk) disable iff (rst)
    dac_sync_n |-> !dac_sdata);
endmodule

// File: tb/dac_serial_writer_test.sv
`timescale 1ns/1ps
module dac_serial_writer_test;
  localparam int CLK_PS = 4000;

  function automatic int to_cyc(input int ps);
    return (ps + CLK_PS - 1) / CLK_PS;
  endfunction

  localparam int MIN_PERIOD = to_cyc(33000);
  localparam int MIN_PHASE  = to_cyc(5000);
  localparam int MIN_LEAD   = to_cyc(10000);
  localparam int MIN_DSU    = to_cyc(5000);
  localparam int MIN_DH     = to_cyc(4500);
  localparam int MIN_HIGH   = to_cyc(20000);
  localparam int MIN_IGN    = to_cyc(13000);

  localparam int NVEC = 8;
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001,
                                         16'h7FFE, 16'h1234, 16'h5555, 16'hAAAA};

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] word_in = '0;
  logic word_valid = 1'b0;
  logic word_ready, dac_sync_n, dac_sclk, dac_sdata;

  int total = 0, bad = 0;
  logic [15:0] exp_w [32];
  int exp_n = 0;
  logic [15:0] rx_w [32];
  int rx_n = 0;

  always #2 clk = ~clk;

  dac_serial_writer uut (
    .clk(clk), .rst(rst), .word_in(word_in), .word_valid(word_valid),
    .word_ready(word_ready), .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk),
    .dac_sdata(dac_sdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Receiver model and interval meter, sampled mid-cycle.
  logic p_sync = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0;
  logic [15:0] sh = '0;
  int nb = 0;
  int t_sfall = 100, t_srise = 100, t_fall = 100, t_rise = 100, t_sdo = 100;

  always @(negedge clk) begin
    if (rst) begin
      p_sync = 1'b1; p_sclk = 1'b1; p_sdo = 1'b0; nb = 0;
      t_sfall = 100; t_srise = 100; t_fall = 100; t_rise = 100; t_sdo = 100;
    end else begin
      t_sfall++; t_srise++; t_fall++; t_rise++; t_sdo++;
      if (p_sync && !dac_sync_n) begin
        check(t_srise >= MIN_HIGH, "R7 strobe high time", t_srise, MIN_HIGH);
        nb = 0;
        t_sfall = 0;
      end
      if (p_sclk && !dac_sclk) begin
        if (nb == 0) begin
          check(t_sfall >= MIN_LEAD, "R4 strobe lead", t_sfall, MIN_LEAD);
          check(t_srise >= MIN_IGN, "R7 dead window", t_srise, MIN_IGN);
        end else begin
          check(t_fall >= MIN_PERIOD, "R3 fall spacing", t_fall, MIN_PERIOD);
          check(t_rise >= MIN_PHASE, "R3 high phase", t_rise, MIN_PHASE);
        end
        check(t_sdo >= MIN_DSU, "R5 data setup", t_sdo, MIN_DSU);
        sh = {sh[14:0], dac_sdata};
        nb++;
        t_fall = 0;
      end
      if (!p_sclk && dac_sclk) begin
        check(t_fall >= MIN_PHASE, "R3 low phase", t_fall, MIN_PHASE);
        t_rise = 0;
      end
      if (p_sdo != dac_sdata) begin
        if (nb > 0) check(t_fall >= MIN_DH, "R5 data hold", t_fall, MIN_DH);
        t_sdo = 0;
      end
      if (!p_sync && dac_sync_n) begin
        check(nb == 16, "R9 falls per frame", nb, 16);
        check(dac_sclk, "R6 clock high at strobe rise", dac_sclk, 1);
        rx_w[rx_n] = sh;
        rx_n++;
        t_srise = 0;
      end
      if (dac_sync_n && !dac_sclk) check(0, "R6 clock low while idle", 0, 1);
      if (dac_sync_n && dac_sdata) check(0, "R10 data high while idle", 1, 0);
      if (!dac_sync_n && word_ready) check(0, "R8 ready during frame", 1, 0);
      if (dac_sync_n && t_srise == 8) check(word_ready, "R8 ready after recovery", word_ready, 1);
      p_sync = dac_sync_n; p_sclk = dac_sclk; p_sdo = dac_sdata;
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    word_valid = 1'b1;
    word_in = w;
    exp_w[exp_n] = w;
    exp_n++;
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    while (rx_n < n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    check(dac_sync_n && dac_sclk && !dac_sdata && word_ready, "R1 during reset",
          {dac_sync_n, dac_sclk, dac_sdata, word_ready}, 4'b1101);
    rst = 1'b0;
    @(negedge clk);
    check(dac_sync_n && dac_sclk && !dac_sdata && word_ready, "R1 after reset",
          {dac_sync_n, dac_sclk, dac_sdata, word_ready}, 4'b1101);

    // Vector walk: R2 word content and order
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i]);
      wait_rx(i + 1);
      check(rx_w[i] == VEC[i], "R2 received word", rx_w[i], VEC[i]);
    end

    // R8: second word held valid through a busy frame is kept
    send(16'hC001);
    send(16'h0BAD);
    wait_rx(NVEC + 2);
    check(rx_w[NVEC] == 16'hC001, "R8 first of pair", rx_w[NVEC], 16'hC001);
    check(rx_w[NVEC + 1] == 16'h0BAD, "R8 held word sent", rx_w[NVEC + 1], 16'h0BAD);

    // Reset in mid-frame: partial frame dropped, link idle (R1)
    send(16'hDEAD);
    exp_n--;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(dac_sync_n && dac_sclk && !dac_sdata && word_ready, "R1 mid-frame reset",
          {dac_sync_n, dac_sclk, dac_sdata, word_ready}, 4'b1101);
    rst = 1'b0;
    check(rx_n == NVEC + 2, "R1 partial frame dropped", rx_n, NVEC + 2);
    send(16'h6A95);
    wait_rx(NVEC + 3);
    check(rx_w[NVEC + 2] == 16'h6A95, "R2 word after reset", rx_w[NVEC + 2], 16'h6A95);

    repeat (20) @(negedge clk);
    check(rx_n == exp_n, "R2 frame count", rx_n, exp_n);
    for (int k = 0; k < exp_n; k++)
      check(rx_w[k] == exp_w[k], "R2 final compare", rx_w[k], exp_w[k]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule